// File: doc/BRIEF.md
# Status Byte and Power-On Flag Logic

This block builds the one-byte status word that a serial-bus slave returns during a read, and owns the sticky power-on flag. Once the flag is set, it stays set until the bus master has read the status and ended that read with a STOP. While the flag is set, the block asks the rest of the chip to discard its programmed settings and to put all output ports in high impedance.

The status word is captured at the start of each read byte. A shift register that sends it out therefore sees a value that cannot change mid-byte. The lock indication may come from another clock domain, so it is synchronized before it is captured. The 3-bit converter result is taken as already synchronous.

Top module: `status_por_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, the power-on flag is 1 and status_o reads 8'h80.
- R2: A cycle with por_event_i high sets the flag at the next clock edge. This takes priority over a STOP in the same cycle.
- R3: The flag returns to 0 only at the edge that samples stop_i and read_active_i both high, with por_event_i low.
- R4: A STOP that arrives with read_active_i low, i.e. one that ends a write, leaves the flag set.
- R5: cfg_clear_o and port_hiz_o are high in exactly the cycles in which the flag is set.
- R6: status_o is captured one edge after byte_start_i is sampled high with read_active_i high. The layout is: bit 7 = power-on flag, bit 6 = lock, bits 5..3 = 0, bits 2..0 = converter result (bit 2 = most significant).
- R7: lock_i passes through SYNC_STAGES flip-flops before capture. With the default of 2, a capture at the first or second edge after lock_i changes still shows the old lock value; the third shows the new one.
- R8: status_o holds its value in every cycle without a capture, whatever lock_i and adc_i do.
- R9: A byte_start_i pulse with read_active_i low is ignored: status_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| por_event_i | input | 1 | Supply-low detection, sets the flag |
| lock_i | input | 1 | Phase-lock indication, asynchronous |
| adc_i | input | 3 | Converter result |
| read_active_i | input | 1 | Current transaction is a read |
| byte_start_i | input | 1 | Start of an outgoing read byte |
| stop_i | input | 1 | STOP condition seen on the bus |
| status_o | output | 8 | Captured status byte |
| cfg_clear_o | output | 1 | Hold programmed registers cleared |
| port_hiz_o | output | 1 | Force output ports to high impedance |

## Verification
The hardest case to reach is the clear of the flag, because only one combination of inputs permits it. The stimulus therefore sends a write-terminating STOP first and checks that the flag survives. It then sends a read STOP, and after that a STOP together with a supply event, so that the priority rule is seen from both sides. The synchronizer latency is measured by capturing on three consecutive edges right after lock_i toggles.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int ADC_W  = 3;
  localparam int BYTE_W = 8;
  localparam int RSVD_W = BYTE_W - ADC_W - 2;

  typedef struct packed {
    logic              por;
    logic              lock;
    logic [RSVD_W-1:0] rsvd;
    logic [ADC_W-1:0]  adc;
  } status_t;

  localparam status_t STATUS_RST = '{por: 1'b1, lock: 1'b0, rsvd: '0, adc: '0};
endpackage

// File: rtl/por_flag_reg.sv
module por_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_event_i,
  input  logic read_active_i,
  input  logic stop_i,
  output logic flag_o
);
  logic flag_q;
  logic read_stop;

  assign read_stop = stop_i & read_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b1;
    else if (por_event_i) flag_q <= 1'b1;
    else if (read_stop)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_on_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_event_i |=> flag_q);
  p_clear_on_read_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_stop && !por_event_i) |=> !flag_q);
  p_write_stop_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && stop_i && !read_active_i) |=> flag_q);
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !read_stop) |=> flag_q);
endmodule

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/status_capture.sv
module status_capture
  import status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             por_i,
  input  logic             lock_i,
  input  logic [ADC_W-1:0] adc_i,
  output status_t          status_o
);
  status_t status_q;
  status_t status_d;

  always_comb begin
    status_d      = status_q;
    if (capture_i) begin
      status_d.por  = por_i;
      status_d.lock = lock_i;
      status_d.rsvd = '0;
      status_d.adc  = adc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= STATUS_RST;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  p_capture_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (status_q.adc == $past(adc_i)) && (status_q.por == $past(por_i))
                  && (status_q.lock == $past(lock_i)));
  p_hold_between_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(status_q));
endmodule

// File: rtl/status_por_ctrl.sv
module status_por_ctrl
  import status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_event_i,
  input  logic             lock_i,
  input  logic [ADC_W-1:0] adc_i,
  input  logic             read_active_i,
  input  logic             byte_start_i,
  input  logic             stop_i,
  output logic [BYTE_W-1:0] status_o,
  output logic             cfg_clear_o,
  output logic             port_hiz_o
);
  logic    flag;
  logic    lock_s;
  logic    capture;
  status_t status;

  por_flag_reg u_flag (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .por_event_i   (por_event_i),
    .read_active_i (read_active_i),
    .stop_i        (stop_i),
    .flag_o        (flag)
  );

  lock_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_i),
    .q_o    (lock_s)
  );

  // capture only for bytes of a read transaction
  assign capture = byte_start_i & read_active_i;

  status_capture u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .por_i     (flag),
    .lock_i    (lock_s),
    .adc_i     (adc_i),
    .status_o  (status)
  );

  assign status_o    = status;
  assign cfg_clear_o = flag;
  assign port_hiz_o  = flag;

  p_ignore_outside_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_start_i && !read_active_i) |=> $stable(status_o));
  p_rsvd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(capture) |-> (status_o[5:3] == 3'b000));
endmodule

// File: tb/tb_status_por_ctrl.sv
module tb_status_por_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_event_i = 1'b0;
  logic       lock_i = 1'b0;
  logic [2:0] adc_i = 3'd0;
  logic       read_active_i = 1'b0;
  logic       byte_start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] status_o;
  logic       cfg_clear_o;
  logic       port_hiz_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  status_por_ctrl dut (
    .clk_i, .rst_ni, .por_event_i, .lock_i, .adc_i, .read_active_i,
    .byte_start_i, .stop_i, .status_o, .cfg_clear_o, .port_hiz_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic capture_byte();
    read_active_i = 1'b1; byte_start_i = 1'b1;
    step();
    byte_start_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status in reset", status_o, 8'h80);
    check("R5 hiz in reset", {7'd0, port_hiz_o}, 8'd1);
    rst_ni = 1'b1;
    step();
    check("R1 status after reset", status_o, 8'h80);
    check("R5 clear after reset", {7'd0, cfg_clear_o}, 8'd1);
  endtask

  task automatic t_write_stop();
    read_active_i = 1'b0; stop_i = 1'b1;
    step();
    stop_i = 1'b0;
    check("R4 write stop keeps flag", {6'd0, cfg_clear_o, port_hiz_o}, 8'd3);
    step();
    check("R4 flag still set", {7'd0, port_hiz_o}, 8'd1);
  endtask

  task automatic t_read_stop();
    adc_i = 3'd5;
    capture_byte();
    check("R6 status with flag", status_o, 8'h85);
    stop_i = 1'b1;
    step();
    stop_i = 1'b0; read_active_i = 1'b0;
    check("R3 read stop clears", {6'd0, cfg_clear_o, port_hiz_o}, 8'd0);
    check("R8 status held after stop", status_o, 8'h85);
    capture_byte();
    check("R6 flag bit now 0", status_o, 8'h05);
    read_active_i = 1'b0;
  endtask

  task automatic t_event_priority();
    por_event_i = 1'b1; stop_i = 1'b1; read_active_i = 1'b1;
    step();
    por_event_i = 1'b0; stop_i = 1'b0; read_active_i = 1'b0;
    check("R2 event beats stop", {7'd0, cfg_clear_o}, 8'd1);
    read_active_i = 1'b1; stop_i = 1'b1;
    step();
    stop_i = 1'b0; read_active_i = 1'b0;
    check("R3 cleared again", {7'd0, port_hiz_o}, 8'd0);
    por_event_i = 1'b1;
    step();
    por_event_i = 1'b0;
    check("R2 event sets flag", {6'd0, cfg_clear_o, port_hiz_o}, 8'd3);
    read_active_i = 1'b1; stop_i = 1'b1;
    step();
    stop_i = 1'b0; read_active_i = 1'b0;
  endtask

  task automatic t_lock_sync();
    adc_i = 3'd2;
    lock_i = 1'b1;
    read_active_i = 1'b1; byte_start_i = 1'b1;
    step();
    check("R7 first edge old lock", status_o, 8'h02);
    step();
    check("R7 second edge old lock", status_o, 8'h02);
    step();
    byte_start_i = 1'b0;
    check("R7 third edge new lock", status_o, 8'h42);
    read_active_i = 1'b0;
  endtask

  task automatic t_hold_and_ignore();
    adc_i = 3'd7; lock_i = 1'b0;
    for (int i = 0; i < 5; i++) step();
    check("R8 held without capture", status_o, 8'h42);
    read_active_i = 1'b0; byte_start_i = 1'b1;
    step();
    byte_start_i = 1'b0;
    check("R9 ignored outside read", status_o, 8'h42);
    capture_byte();
    read_active_i = 1'b0;
    check("R6 adc all ones, unlocked", status_o, 8'h07);
  endtask

  initial begin
    step();
    t_reset();
    t_write_stop();
    t_read_stop();
    t_event_priority();
    t_lock_sync();
    t_hold_and_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule